// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block turns a parallel word into a bit stream on a single wire. A row of storage stages, one per bit, is either loaded as a whole from a parallel bus or moved one place toward the serial output on each rising clock edge. The stage count is a parameter and defaults to 8.

A single active-low control picks the operation: low loads the word, high shifts. During a shift a fresh bit enters the first stage from a serial input. Longer registers are built by chaining the serial output of one instance into the serial input of the next. An inhibit input freezes the register on any edge where it is high. A synchronous active-high reset clears every stage.

All decisions are sampled on the rising edge, so the load is synchronous. The state of every stage is also brought out.

Top module: `plsr_shift_reg`

## Requirements
- R1: With `rst` high at a rising edge, every stage becomes 0 on that edge, whatever the other inputs are.
- R2: With `rst` low, `inhibit` low and `shld_n` low at a rising edge, stage i takes `par_in[i]`, and all stages load together.
- R3: With `rst` low, `inhibit` low and `shld_n` high at a rising edge, stage 0 takes `ser_in` and stage i+1 takes the old value of stage i.
- R4: `ser_out` always equals `stage_q[STAGES-1]`, the last stage.
- R5: With `rst` low and `inhibit` high at a rising edge, all stages keep their values, even when `shld_n` asks for a load or a shift.
- R6: During a load, `ser_in` has no effect. Stage 0 takes `par_in[0]`.
- R7: A 1 shifted in on `ser_in` first appears on `ser_out` after exactly STAGES shift edges.
- R8: After a load followed by STAGES shifts with `ser_in` at 0, all stages read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous clear, active high |
| shld_n | input | 1 | 0 = parallel load, 1 = shift toward output |
| inhibit | input | 1 | 1 = ignore the edge and hold the contents |
| ser_in | input | 1 | Bit entering stage 0 on a shift |
| par_in | input | STAGES | Parallel word; bit i goes to stage i |
| stage_q | output | STAGES | Current contents of every stage |
| ser_out | output | 1 | Last stage, i.e. the serial stream |

## Verification
The bench builds two instances. The default 8-stage instance runs a long seeded random mix of reset, inhibit, load and shift. This exercises every priority pairing between the controls and the full STAGES-edge travel of a bit from `ser_in` to `ser_out`. A 3-stage instance replays a short directed load-then-shift sequence with a known value at each step. It also shows that the stage count parameter is honoured at a width other than the default.

// File: rtl/plsr_pkg.sv
`timescale 1ns/1ps
package plsr_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_CLEAR = 2'd1,
      OP_LOAD  = 2'd2,
      OP_SHIFT = 2'd3
   } plsr_op_t;
endpackage

// File: rtl/plsr_ctrl.sv
`timescale 1ns/1ps
module plsr_ctrl
   import plsr_pkg::*;
(
   input  logic     rst,
   input  logic     shld_n,
   input  logic     inhibit,
   output plsr_op_t op
);
   // Order of precedence: clear, then hold on inhibit, then load, then shift.
   always_comb begin
      if (rst)          op = OP_CLEAR;
      else if (inhibit) op = OP_HOLD;
      else if (!shld_n) op = OP_LOAD;
      else              op = OP_SHIFT;
   end
endmodule

// File: rtl/plsr_stage.sv
`timescale 1ns/1ps
module plsr_stage
   import plsr_pkg::*;
(
   input  logic     clk,
   input  plsr_op_t op,
   input  logic     par_bit,
   input  logic     prev_bit,
   output logic     q
);
   always_ff @(posedge clk) begin
      case (op)
         OP_CLEAR: q <= 1'b0;
         OP_LOAD:  q <= par_bit;
         OP_SHIFT: q <= prev_bit;
         default:  q <= q;
      endcase
   end
endmodule

// File: rtl/plsr_shift_reg.sv
`timescale 1ns/1ps
module plsr_shift_reg
   import plsr_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shld_n,
   input  logic              inhibit,
   input  logic              ser_in,
   input  logic [STAGES-1:0] par_in,
   output logic [STAGES-1:0] stage_q,
   output logic              ser_out
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("plsr_shift_reg: STAGES must be at least 2");
      end
   endgenerate

   plsr_op_t op;

   plsr_ctrl u_ctrl (
      .rst     (rst),
      .shld_n  (shld_n),
      .inhibit (inhibit),
      .op      (op)
   );

   // chain[i] feeds stage i on a shift; chain[0] is the serial input
   logic [STAGES-1:0] chain;
   assign chain = {stage_q[LAST-1:0], ser_in};

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      plsr_stage u_stage (
         .clk      (clk),
         .op       (op),
         .par_bit  (par_in[i]),
         .prev_bit (chain[i]),
         .q        (stage_q[i])
      );
   end

   assign ser_out = stage_q[LAST];

   // R1: reset clears everything on the next edge
   a_r1_clear: assert property (@(posedge clk)
      rst |=> (stage_q == '0));

   // R2 / R6: load copies the bus, ser_in plays no part
   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      (!inhibit && !shld_n) |=> (stage_q == $past(par_in)));

   // R3: shift moves one place and takes ser_in into stage 0
   a_r3_shift: assert property (@(posedge clk) disable iff (rst)
      (!inhibit && shld_n) |=> (stage_q == {$past(stage_q[LAST-1:0]), $past(ser_in)}));

   // R4: serial output tracks the bit that was one stage back before a shift
   a_r4_ser_out: assert property (@(posedge clk) disable iff (rst)
      (!inhibit && shld_n) |=> (ser_out == $past(stage_q[LAST-1])));

   // R5: inhibit freezes the register
   a_r5_inhibit: assert property (@(posedge clk) disable iff (rst)
      inhibit |=> $stable(stage_q));
endmodule

// File: tb/plsr_shift_reg_bench.sv
`timescale 1ns/1ps
module plsr_shift_reg_bench;
   localparam int S  = 8;
   localparam int S3 = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst, shld_n, inhibit, ser_in;
   logic [S-1:0] par_in, stage_q;
   logic         ser_out;

   logic          rst3, shld_n3, inhibit3, ser_in3;
   logic [S3-1:0] par_in3, stage_q3;
   logic          ser_out3;

   plsr_shift_reg #(.STAGES(S)) u_plsr_shift_reg (
      .clk(clk), .rst(rst), .shld_n(shld_n), .inhibit(inhibit), .ser_in(ser_in),
      .par_in(par_in), .stage_q(stage_q), .ser_out(ser_out));

   plsr_shift_reg #(.STAGES(S3)) u_plsr_shift_reg_3 (
      .clk(clk), .rst(rst3), .shld_n(shld_n3), .inhibit(inhibit3), .ser_in(ser_in3),
      .par_in(par_in3), .stage_q(stage_q3), .ser_out(ser_out3));

   int n_cmp = 0;
   int n_bad = 0;
   logic [S-1:0] model;
   string last_tag;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [S-1:0] next_state(input logic [S-1:0] cur, input logic r,
      input logic inh, input logic sl, input logic si, input logic [S-1:0] p);
      if (r)        return '0;
      else if (inh) return cur;
      else if (!sl) return p;
      else          return {cur[S-2:0], si};
   endfunction

   // one cycle: check result of previous edge, then drive the next edge's inputs
   task automatic step(input logic r, input logic inh, input logic sl, input logic si,
                       input logic [S-1:0] p);
      @(negedge clk);
      check({last_tag, " stages"}, 32'(stage_q), 32'(model));
      check("R4 ser_out", 32'(ser_out), 32'(model[S-1]));
      rst = r; inhibit = inh; shld_n = sl; ser_in = si; par_in = p;
      model = next_state(model, r, inh, sl, si, p);
      if (r)        last_tag = "R1 reset";
      else if (inh) last_tag = "R5 inhibit";
      else if (!sl) last_tag = "R2/R6 load";
      else          last_tag = "R3 shift";
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      int hits;
      seed = 32'h5eed1234;
      void'($urandom(seed));
      rst = 1; inhibit = 0; shld_n = 1; ser_in = 0; par_in = '0;
      rst3 = 1; inhibit3 = 0; shld_n3 = 1; ser_in3 = 0; par_in3 = '0;
      model = '0; last_tag = "R1 reset";
      step(1, 0, 0, 1, 8'hFF);
      step(1, 1, 1, 1, 8'hFF);                 // R1 reset beats inhibit
      step(0, 0, 1, 0, 8'h00);

      // R6: load while ser_in is 1 and par_in[0] is 0
      step(0, 0, 0, 1, 8'hA4);
      // R5: inhibit against load and against shift
      step(0, 1, 0, 0, 8'h3C);
      step(0, 1, 1, 1, 8'h3C);
      // R8: word drains after S shifts with ser_in 0
      for (int i = 0; i < S; i++) step(0, 0, 1, 0, 8'h00);
      @(negedge clk);
      check("R8 drained", 32'(stage_q), 32'h0);

      // R7: a single 1 on ser_in reaches ser_out after exactly S shifts
      step(0, 0, 1, 1, 8'h00);
      hits = 0;
      for (int i = 1; i < S; i++) begin
         step(0, 0, 1, 0, 8'h00);
         @(posedge clk); #1;
         if (ser_out) hits = i;
      end
      check("R7 not early", 32'(hits), 32'(S - 1));
      step(0, 0, 1, 0, 8'h00);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = $urandom_range(0, 99);
         step(k < 3, (k >= 3 && k < 20), !(k >= 20 && k < 40), 1'($urandom), 8'($urandom));
      end
      step(0, 0, 1, 0, 8'h00);

      // 3-stage directed: load 101, then shift with ser_in 0
      @(negedge clk); rst3 = 1;
      @(negedge clk); rst3 = 0;
      check("R1 reset 3-stage", 32'(stage_q3), 32'h0);
      shld_n3 = 0; par_in3 = 3'b101;
      @(negedge clk); shld_n3 = 1; ser_in3 = 0;
      check("R2 load 3-stage", 32'(stage_q3), 32'h5);
      @(negedge clk);
      check("R3 first shift 3-stage", 32'(stage_q3), 32'h2);
      @(negedge clk);
      check("R3 second shift 3-stage", 32'(stage_q3), 32'h4);
      check("R4 ser_out 3-stage", 32'(ser_out3), 32'h1);
      @(negedge clk);
      check("R8 drained 3-stage", 32'(stage_q3), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule